// File: doc/BRIEF.md
# Smart Card Character Receiver

This block takes characters from a single open-drain smart-card I/O line, where the sender and receiver take turns on the same wire. Each character has a low start bit, eight data bits with the least significant bit first, and one parity bit. The bit time is a fixed number of clock ticks, set by a parameter. A two-stage synchronizer brings the line into the clock domain. A small frame engine samples each bit once at the middle of its bit time, counting from the falling edge of the start bit. It then checks even parity over the nine data and parity bits. When parity fails, the receiver pulls the line low for one bit time. This tells the sender to send the same character again.

Each completed character goes into a byte register. Three sticky flags follow it: ready, parity error and overrun. The ready flag and the DMA pins form a valid/ready stream. `dma_req` is the valid signal and `dma_ack` is the ready signal, and a byte moves when both are high in the same clock. Back-pressure works as follows. While `dma_ack` stays low, the byte and `dma_req` hold. If a further character completes before the handshake, the overrun flag is set and the held byte is kept. A receive interrupt and an error interrupt, both gated by one enable, report to software. Software clears each flag with a one-cycle clear pulse.

Top module: `sc_char_rx`

## Requirements
- R1: After reset all three flags, both interrupts, `dma_req` and `sc_io_pull_low` are 0.
- R2: A character is a start bit (0), then data bits D0..D7 least significant first, then a parity bit that makes the count of ones over the nine bits even. Each bit is sampled once, near the middle of its bit time. A good character loads `rx_byte` and sets `ready_flag`.
- R3: A character with bad parity sets `parity_err_flag`. It leaves `ready_flag` at 0, but `rx_byte` is still loaded with the received byte.
- R4: After a bad parity bit, `sc_io_pull_low` is 1 for exactly BIT_TICKS cycles. It starts half a bit time after the parity sample point. This is 3 + 10*BIT_TICKS clock edges after the first edge at which `sc_io_in` is low for the start bit.
- R5: A character with good parity never raises `sc_io_pull_low`. The receiver accepts a new start bit two bit times after the parity sample point.
- R6: `dma_req` is high when `ready_flag` is 1 and neither error flag is set. A clock with `dma_req` and `dma_ack` both high clears `ready_flag`.
- R7: If a character completes while `ready_flag` is still 1, `overrun_flag` is set and `rx_byte` keeps its earlier value.
- R8: `rx_irq` equals `irq_en` AND `ready_flag`. `err_irq` equals `irq_en` AND (`parity_err_flag` OR `overrun_flag`). No DMA request is issued while either error flag is set.
- R9: Each flag stays set until its clear pulse. If a set and a clear happen in the same clock, the set wins.
- R10: If the line is low at the start-bit sample point, that counts as a start. If the line is back high at that point, the low was a glitch. The glitch is discarded with no flag change, and the next real character is received normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sc_io_in | input | 1 | Level of the shared I/O line; idles high |
| sc_io_pull_low | output | 1 | Enable for the open-drain pull-down on the line |
| irq_en | input | 1 | Enable for both interrupts |
| clr_ready | input | 1 | One-cycle pulse that clears the ready flag |
| clr_parity_err | input | 1 | One-cycle pulse that clears the parity-error flag |
| clr_overrun | input | 1 | One-cycle pulse that clears the overrun flag |
| rx_byte | output | 8 | Receive data register |
| ready_flag | output | 1 | A byte is held and has not yet been taken |
| parity_err_flag | output | 1 | Sticky parity-error flag |
| overrun_flag | output | 1 | Sticky overrun flag |
| rx_irq | output | 1 | Receive interrupt request |
| err_irq | output | 1 | Error interrupt request |
| dma_req | output | 1 | Valid side of the byte stream |
| dma_ack | input | 1 | Ready side of the byte stream |

## Verification
The line change for the start bit reaches the frame engine after three clock edges: two synchronizer stages and the idle check. The parity sample then comes HALF + 9*BIT_TICKS edges later, and the flags and `rx_byte` change one edge after that. The pull-low starts at edge 3 + 10*BIT_TICKS. The bench counts edges from the clock at which it drives the start bit. It compares the exact edge of the first pull-low and the exact number of pull-low cycles. It reads the flags only after a full guard time, and it checks handshake and clear effects at the falling edge after the rising edge that applies them.

// File: rtl/sc_rx_pkg.sv
package sc_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_GAP,
    ST_ERR,
    ST_TAIL
  } rx_state_t;
endpackage

// File: rtl/sc_rx_sync.sv
module sc_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b1;
          else        chain[0] <= d_in;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= 1'b1;
          else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign d_out = chain[STAGES-1];
endmodule

// File: rtl/sc_rx_frame.sv
module sc_rx_frame
  import sc_rx_pkg::*;
#(
  parameter int BIT_TICKS = 372,
  parameter int DW        = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_s,
  output logic          done,
  output logic          par_ok,
  output logic [DW-1:0] data,
  output logic          pull_low
);
  localparam int HALF = BIT_TICKS / 2;
  localparam int CW   = $clog2(BIT_TICKS + 1);
  localparam int BW   = $clog2(DW);
  localparam logic [CW-1:0] BIT_LAST  = CW'(BIT_TICKS - 1);
  localparam logic [CW-1:0] HALF_LAST = CW'(HALF - 1);
  localparam logic [BW-1:0] IDX_LAST  = BW'(DW - 1);

  rx_state_t     st;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bidx;
  logic [DW-1:0] shreg;
  logic          bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      cnt   <= '0;
      bidx  <= '0;
      shreg <= '0;
      bad   <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: if (!line_s) begin
          st  <= ST_START;
          cnt <= '0;
        end
        ST_START: if (cnt == HALF_LAST) begin
          cnt  <= '0;
          bidx <= '0;
          st   <= line_s ? ST_IDLE : ST_DATA;
        end else cnt <= cnt + 1'b1;
        ST_DATA: if (cnt == BIT_LAST) begin
          cnt   <= '0;
          shreg <= {line_s, shreg[DW-1:1]};
          if (bidx == IDX_LAST) st <= ST_PAR;
          else                  bidx <= bidx + 1'b1;
        end else cnt <= cnt + 1'b1;
        ST_PAR: if (cnt == BIT_LAST) begin
          cnt  <= '0;
          bad  <= ^{line_s, shreg};
          done <= 1'b1;
          st   <= ST_GAP;
        end else cnt <= cnt + 1'b1;
        ST_GAP: if (cnt == HALF_LAST) begin
          cnt <= '0;
          st  <= ST_ERR;
        end else cnt <= cnt + 1'b1;
        ST_ERR: if (cnt == BIT_LAST) begin
          cnt <= '0;
          st  <= ST_TAIL;
        end else cnt <= cnt + 1'b1;
        ST_TAIL: if (cnt == HALF_LAST) begin
          cnt <= '0;
          st  <= ST_IDLE;
        end else cnt <= cnt + 1'b1;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign par_ok   = !bad;
  assign data     = shreg;
  assign pull_low = (st == ST_ERR) && bad;
endmodule

// File: rtl/sc_rx_status.sv
module sc_rx_status #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          done,
  input  logic          par_ok,
  input  logic [DW-1:0] data_in,
  input  logic          clr_ready,
  input  logic          clr_parity_err,
  input  logic          clr_overrun,
  input  logic          dma_ack,
  input  logic          irq_en,
  output logic [DW-1:0] rx_byte,
  output logic          ready_flag,
  output logic          parity_err_flag,
  output logic          overrun_flag,
  output logic          rx_irq,
  output logic          err_irq,
  output logic          dma_req
);
  logic take;
  logic slot_free;

  assign take      = dma_req && dma_ack;
  assign slot_free = !ready_flag || take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_byte         <= '0;
      ready_flag      <= 1'b0;
      parity_err_flag <= 1'b0;
      overrun_flag    <= 1'b0;
    end else begin
      if (clr_ready || take) ready_flag <= 1'b0;
      if (clr_parity_err)    parity_err_flag <= 1'b0;
      if (clr_overrun)       overrun_flag <= 1'b0;
      if (done) begin
        if (!slot_free) overrun_flag <= 1'b1;
        else begin
          rx_byte <= data_in;
          if (par_ok) ready_flag <= 1'b1;
        end
        if (!par_ok) parity_err_flag <= 1'b1;
      end
    end
  end

  assign dma_req = ready_flag && !parity_err_flag && !overrun_flag;
  assign rx_irq  = irq_en && ready_flag;
  assign err_irq = irq_en && (parity_err_flag || overrun_flag);
endmodule

// File: rtl/sc_char_rx.sv
module sc_char_rx #(
  parameter int BIT_TICKS   = 372,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sc_io_in,
  output logic       sc_io_pull_low,
  input  logic       irq_en,
  input  logic       clr_ready,
  input  logic       clr_parity_err,
  input  logic       clr_overrun,
  output logic [7:0] rx_byte,
  output logic       ready_flag,
  output logic       parity_err_flag,
  output logic       overrun_flag,
  output logic       rx_irq,
  output logic       err_irq,
  output logic       dma_req,
  input  logic       dma_ack
);
  localparam int DW = 8;

  logic          line_s;
  logic          frame_done;
  logic          frame_par_ok;
  logic [DW-1:0] frame_data;

  sc_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (sc_io_in),
    .d_out (line_s)
  );

  sc_rx_frame #(.BIT_TICKS(BIT_TICKS), .DW(DW)) u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_s   (line_s),
    .done     (frame_done),
    .par_ok   (frame_par_ok),
    .data     (frame_data),
    .pull_low (sc_io_pull_low)
  );

  sc_rx_status #(.DW(DW)) u_status (
    .clk             (clk),
    .rst_n           (rst_n),
    .done            (frame_done),
    .par_ok          (frame_par_ok),
    .data_in         (frame_data),
    .clr_ready       (clr_ready),
    .clr_parity_err  (clr_parity_err),
    .clr_overrun     (clr_overrun),
    .dma_ack         (dma_ack),
    .irq_en          (irq_en),
    .rx_byte         (rx_byte),
    .ready_flag      (ready_flag),
    .parity_err_flag (parity_err_flag),
    .overrun_flag    (overrun_flag),
    .rx_irq          (rx_irq),
    .err_irq         (err_irq),
    .dma_req         (dma_req)
  );
endmodule

// File: rtl/sc_char_rx_chk.sv
module sc_char_rx_chk #(
  parameter int BIT_TICKS = 372
) (
  input logic       clk,
  input logic       rst_n,
  input logic       done,
  input logic       par_ok,
  input logic       pull,
  input logic       ready_flag,
  input logic       parity_err_flag,
  input logic       overrun_flag,
  input logic       dma_req,
  input logic       dma_ack,
  input logic [7:0] rx_byte
);
  localparam int RW = $clog2(BIT_TICKS + 2);
  logic [RW-1:0] run;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    run <= '0;
    else if (pull) run <= run + 1'b1;
    else           run <= '0;

  AST_PULL_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    pull |-> (run < RW'(BIT_TICKS))); // R4

  AST_BAD_SETS_PER: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !par_ok) |=> parity_err_flag); // R3

  AST_BAD_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !par_ok && !ready_flag) |=> !ready_flag); // R3

  AST_GOOD_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (done && par_ok && !ready_flag) |=> ready_flag); // R2

  AST_TAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && dma_ack && !done) |=> !ready_flag); // R6

  AST_OVR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ready_flag && !dma_ack) |=> (overrun_flag && $stable(rx_byte))); // R7
endmodule

bind sc_char_rx sc_char_rx_chk #(.BIT_TICKS(BIT_TICKS)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .done            (frame_done),
  .par_ok          (frame_par_ok),
  .pull            (sc_io_pull_low),
  .ready_flag      (ready_flag),
  .parity_err_flag (parity_err_flag),
  .overrun_flag    (overrun_flag),
  .dma_req         (dma_req),
  .dma_ack         (dma_ack),
  .rx_byte         (rx_byte)
);

// File: tb/sim_sc_char_rx.sv
`timescale 1ns/1ps
module sim_sc_char_rx;
  localparam int BIT = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sender = 1'b1;
  logic irq_en = 1'b1;
  logic clr_ready = 1'b0, clr_parity_err = 1'b0, clr_overrun = 1'b0;
  logic dma_ack = 1'b0;
  logic pull;
  logic [7:0] rx_byte;
  logic ready_flag, parity_err_flag, overrun_flag, rx_irq, err_irq, dma_req;
  wire  line = sender & ~pull;

  int checks = 0, fails = 0;
  int cyc = 0, start_cyc = 0;
  int ecnt = 0, efirst = -1;
  bit finished = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sc_char_rx #(.BIT_TICKS(BIT)) u0 (
    .clk(clk), .rst_n(rst_n), .sc_io_in(line), .sc_io_pull_low(pull),
    .irq_en(irq_en), .clr_ready(clr_ready), .clr_parity_err(clr_parity_err),
    .clr_overrun(clr_overrun), .rx_byte(rx_byte), .ready_flag(ready_flag),
    .parity_err_flag(parity_err_flag), .overrun_flag(overrun_flag),
    .rx_irq(rx_irq), .err_irq(err_irq), .dma_req(dma_req), .dma_ack(dma_ack)
  );

  always @(negedge clk)
    if (pull) begin
      if (ecnt == 0) efirst = cyc - start_cyc;
      ecnt = ecnt + 1;
    end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic hold_bit(logic v);
    sender = v;
    repeat (BIT) @(negedge clk);
  endtask

  task automatic send_char(logic [7:0] b, bit bad);
    ecnt = 0;
    efirst = -1;
    @(negedge clk);
    start_cyc = cyc;
    hold_bit(1'b0);
    for (int i = 0; i < 8; i++) hold_bit(b[i]);
    hold_bit((^b) ^ bad);
    sender = 1'b1;
    repeat (3 * BIT) @(negedge clk);
  endtask

  task automatic pulse_ack();
    dma_ack = 1'b1; @(negedge clk); dma_ack = 1'b0;
  endtask

  task automatic pulse_clr(bit r, bit p, bit o);
    clr_ready = r; clr_parity_err = p; clr_overrun = o;
    @(negedge clk);
    clr_ready = 1'b0; clr_parity_err = 1'b0; clr_overrun = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #800000;
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 ready", ready_flag, 0);
    check("R1 parity_err", parity_err_flag, 0);
    check("R1 overrun", overrun_flag, 0);
    check("R1 irqs", {rx_irq, err_irq}, 0);
    check("R1 dma_req", dma_req, 0);
    check("R1 pull", pull, 0);

    // R2 R5 R6 R8: sweep every byte value with good parity
    for (int b = 0; b < 256; b++) begin
      send_char(8'(b), 1'b0);
      check("R2 data", rx_byte, b);
      check("R2 ready", ready_flag, 1);
      check("R5 no pull", ecnt, 0);
      check("R8 rx_irq", rx_irq, 1);
      check("R6 dma_req", dma_req, 1);
      pulse_ack();
      check("R6 ack clears", ready_flag, 0);
    end

    // R3 R4: bad parity
    send_char(8'hA5, 1'b1);
    check("R3 parity_err", parity_err_flag, 1);
    check("R3 no ready", ready_flag, 0);
    check("R3 data loaded", rx_byte, 8'hA5);
    check("R4 pull start edge", efirst, 3 + 10 * BIT);
    check("R4 pull length", ecnt, BIT);
    check("R8 err_irq", err_irq, 1);
    check("R8 no dma on error", dma_req, 0);

    // R9 R8: retransfer; sticky flag blocks DMA until cleared
    send_char(8'hA5, 1'b0);
    check("R2 retransfer ready", ready_flag, 1);
    check("R9 parity_err sticky", parity_err_flag, 1);
    check("R8 dma blocked", dma_req, 0);
    pulse_clr(1'b0, 1'b1, 1'b0);
    check("R9 parity_err cleared", parity_err_flag, 0);
    check("R6 dma after clear", dma_req, 1);
    pulse_ack();

    // R7 overrun
    send_char(8'h3C, 1'b0);
    send_char(8'hC3, 1'b0);
    check("R7 overrun", overrun_flag, 1);
    check("R7 data kept", rx_byte, 8'h3C);
    check("R7 no dma", dma_req, 0);
    check("R8 err_irq overrun", err_irq, 1);
    pulse_clr(1'b1, 1'b0, 1'b1);
    check("R9 overrun cleared", overrun_flag, 0);
    check("R9 ready cleared", ready_flag, 0);

    // R8 interrupts gated off
    irq_en = 1'b0;
    send_char(8'h5A, 1'b1);
    check("R8 err_irq gated", err_irq, 0);
    send_char(8'h5A, 1'b0);
    check("R8 rx_irq gated", rx_irq, 0);
    check("R8 ready still set", ready_flag, 1);
    pulse_clr(1'b1, 1'b1, 1'b0);
    irq_en = 1'b1;

    // R10 start glitch
    @(negedge clk); sender = 1'b0;
    @(negedge clk); sender = 1'b1;
    repeat (12 * BIT) @(negedge clk);
    check("R10 glitch no ready", ready_flag, 0);
    check("R10 glitch no error", parity_err_flag, 0);
    send_char(8'h81, 1'b0);
    check("R10 after glitch data", rx_byte, 8'h81);
    check("R10 after glitch ready", ready_flag, 1);

    finish_run();
  end
endmodule